// File: doc/BRIEF.md
# Jacobian Scalar Multiplication Sequencer

This block multiplies a point P of a short Weierstrass curve with zero linear coefficient (y² = x³ + b over a prime field) by a scalar. It runs a left-to-right double-and-add loop in Jacobian coordinates, where a triple (X : Y : Z) stands for the affine point (X/Z², Y/Z³). The scalar port carries the bits below an implied leading one. The result is therefore (2^KW + k)·P, where k is the value on the scalar port.

Doubling and addition are not built as parallel formula hardware. Each is a fixed micro-op program executed on one shared modular multiplier, one modular adder and one modular subtractor. Intermediate values live in a small register file. Squarings go to the multiplier. Small constant multiples are built from chains of modular additions. The caller pulses start with the scalar, the affine base point and the prime. It then waits for the done pulse and reads the Jacobian result and an infinity flag. Conversion back to affine form is left to the caller.

Top module: `ecj_scalar_mul`

## Requirements
- R1: When done pulses, (x_out/z_out², y_out/z_out³) mod prime equals (2^KW + k)·P. Scalar bits are taken from bit KW-1 down to bit 0; each step doubles, then adds P if the bit is 1.
- R2: A doubling with Y = 0, or an addition in which the running point has the same affine x as P, collapses the result to Z = 0, and Z stays 0 for the rest of the run. at_inf is 1 exactly when z_out is 0 at done.
- R3: x_out, y_out, z_out and every value written to the register file are below prime.
- R4: done is high for exactly one cycle, and the outputs keep their values from one done to the next.
- R5: A start pulse while a run is in progress is ignored. The run finishes with the scalar, point and prime latched when it began.
- R6: After reset, done, at_inf, x_out, y_out and z_out are all 0.
- R7: A zero scalar yields 2^KW·P using only doublings, and an all-ones scalar adds P at every step.
- R8: The number of cycles from start to done is A + KW·D + popcount(k)·E, where A, D and E are constants.
- R9: Each multiply takes a fixed W cycles and never overlaps another. The run time does not depend on the operand values or on the prime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (used only when idle) |
| scalar | input | KW | Scalar bits below the implied leading one |
| base_x | input | W | Affine x of P, below prime |
| base_y | input | W | Affine y of P, below prime |
| prime | input | W | Odd field prime |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | W | Jacobian X of the result |
| y_out | output | W | Jacobian Y of the result |
| z_out | output | W | Jacobian Z of the result |
| at_inf | output | 1 | Result is the point at infinity (Z = 0) |

## Verification
The range assertions assume that the prime is odd and that base_x and base_y are already reduced below it. The correctness checks also assume the base point lies on the curve. The bench uses primes congruent to 3 mod 4, so it can take square roots by exponentiation. It draws a random x, searches upward for a point whose y is nonzero and finds y by that square root, so every base point is reduced and on the curve. A small prime is included so that degenerate additions and doublings actually occur.

// File: rtl/ecj_pkg.sv
package ecj_pkg;
  localparam int RF_AW    = 4;
  localparam int RF_DEPTH = 1 << RF_AW;
  localparam int PC_W     = 6;
  localparam logic [PC_W-1:0] ADD_ENTRY = PC_W'(24);

  typedef enum logic [1:0] {UOP_MUL, UOP_ADD, UOP_SUB, UOP_RET} uop_e;

  typedef struct packed {
    uop_e             op;
    logic [RF_AW-1:0] d;
    logic [RF_AW-1:0] a;
    logic [RF_AW-1:0] b;
  } uop_t;

  function automatic uop_t mk(uop_e o, int d, int a, int b);
    uop_t u;
    u.op = o;
    u.d  = RF_AW'(d);
    u.a  = RF_AW'(a);
    u.b  = RF_AW'(b);
    return u;
  endfunction
endpackage

// File: rtl/ecj_modarith.sv
module ecj_modarith #(
  parameter int W = 16,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] p,
  output logic [W-1:0] y
);
  generate
    if (SUBTRACT) begin : g_sub
      logic [W:0] diff, wrap;
      assign diff = {1'b0, a} - {1'b0, b};
      assign wrap = diff + {1'b0, p};
      assign y = diff[W] ? wrap[W-1:0] : diff[W-1:0];
    end else begin : g_add
      logic [W:0] sum, red;
      assign sum = {1'b0, a} + {1'b0, b};
      assign red = sum - {1'b0, p};
      assign y = (sum >= {1'b0, p}) ? red[W-1:0] : sum[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ecj_modmul.sv
module ecj_modmul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] p,
  output logic         done,
  output logic [W-1:0] y
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  acc, ar, br;
  logic [CW-1:0] cnt;
  logic          busy;

  function automatic logic [W-1:0] step(logic [W-1:0] acc_i, logic bit_i,
                                        logic [W-1:0] b_i, logic [W-1:0] p_i);
    logic [W:0] dbl, sum;
    dbl = {acc_i, 1'b0};
    if (dbl >= {1'b0, p_i}) dbl = dbl - {1'b0, p_i};
    sum = dbl + (bit_i ? {1'b0, b_i} : '0);
    if (sum >= {1'b0, p_i}) sum = sum - {1'b0, p_i};
    return sum[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      ar   <= '0;
      br   <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc  <= '0;
        ar   <= a;
        br   <= b;
        cnt  <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= step(acc, ar[W-1], br, p);
        ar  <= {ar[W-2:0], 1'b0};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign y = acc;

  AST_MUL_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R9
  AST_MUL_RESULT_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (y < p)); // R3
endmodule

// File: rtl/ecj_uprog.sv
module ecj_uprog
  import ecj_pkg::*;
(
  input  logic [PC_W-1:0] pc,
  output uop_t            uop
);
  // Registers: 0 X, 1 Y, 2 Z of the running point; 3, 4 affine base; 5..15 scratch.
  always_comb begin
    unique case (pc)
      // doubling
      6'd0:  uop = mk(UOP_MUL, 5, 0, 0);
      6'd1:  uop = mk(UOP_MUL, 6, 1, 1);
      6'd2:  uop = mk(UOP_MUL, 7, 0, 6);
      6'd3:  uop = mk(UOP_MUL, 8, 6, 6);
      6'd4:  uop = mk(UOP_MUL, 9, 5, 5);
      6'd5:  uop = mk(UOP_MUL, 10, 1, 2);
      6'd6:  uop = mk(UOP_ADD, 2, 10, 10);
      6'd7:  uop = mk(UOP_ADD, 11, 9, 9);
      6'd8:  uop = mk(UOP_ADD, 11, 11, 11);
      6'd9:  uop = mk(UOP_ADD, 11, 11, 11);
      6'd10: uop = mk(UOP_ADD, 11, 11, 9);
      6'd11: uop = mk(UOP_ADD, 12, 7, 7);
      6'd12: uop = mk(UOP_ADD, 12, 12, 12);
      6'd13: uop = mk(UOP_ADD, 13, 12, 12);
      6'd14: uop = mk(UOP_SUB, 0, 11, 13);
      6'd15: uop = mk(UOP_SUB, 14, 12, 0);
      6'd16: uop = mk(UOP_ADD, 15, 5, 5);
      6'd17: uop = mk(UOP_ADD, 15, 15, 5);
      6'd18: uop = mk(UOP_MUL, 15, 15, 14);
      6'd19: uop = mk(UOP_ADD, 8, 8, 8);
      6'd20: uop = mk(UOP_ADD, 8, 8, 8);
      6'd21: uop = mk(UOP_ADD, 8, 8, 8);
      6'd22: uop = mk(UOP_SUB, 1, 15, 8);
      6'd23: uop = mk(UOP_RET, 0, 0, 0);
      // addition of the affine base point
      6'd24: uop = mk(UOP_MUL, 5, 2, 2);
      6'd25: uop = mk(UOP_MUL, 6, 5, 2);
      6'd26: uop = mk(UOP_MUL, 7, 3, 5);
      6'd27: uop = mk(UOP_SUB, 7, 7, 0);
      6'd28: uop = mk(UOP_MUL, 8, 4, 6);
      6'd29: uop = mk(UOP_SUB, 8, 8, 1);
      6'd30: uop = mk(UOP_ADD, 8, 8, 8);
      6'd31: uop = mk(UOP_MUL, 9, 7, 7);
      6'd32: uop = mk(UOP_MUL, 10, 9, 7);
      6'd33: uop = mk(UOP_MUL, 11, 9, 0);
      6'd34: uop = mk(UOP_ADD, 11, 11, 11);
      6'd35: uop = mk(UOP_ADD, 11, 11, 11);
      6'd36: uop = mk(UOP_ADD, 12, 11, 11);
      6'd37: uop = mk(UOP_ADD, 13, 10, 10);
      6'd38: uop = mk(UOP_ADD, 13, 13, 13);
      6'd39: uop = mk(UOP_MUL, 14, 8, 8);
      6'd40: uop = mk(UOP_SUB, 14, 14, 13);
      6'd41: uop = mk(UOP_SUB, 0, 14, 12);
      6'd42: uop = mk(UOP_SUB, 15, 11, 0);
      6'd43: uop = mk(UOP_MUL, 15, 8, 15);
      6'd44: uop = mk(UOP_MUL, 5, 1, 10);
      6'd45: uop = mk(UOP_ADD, 5, 5, 5);
      6'd46: uop = mk(UOP_ADD, 5, 5, 5);
      6'd47: uop = mk(UOP_ADD, 5, 5, 5);
      6'd48: uop = mk(UOP_SUB, 1, 15, 5);
      6'd49: uop = mk(UOP_MUL, 6, 2, 7);
      6'd50: uop = mk(UOP_ADD, 2, 6, 6);
      default: uop = mk(UOP_RET, 0, 0, 0);
    endcase
  end
endmodule

// File: rtl/ecj_scalar_mul.sv
module ecj_scalar_mul
  import ecj_pkg::*;
#(
  parameter int W  = 16,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [KW-1:0] scalar,
  input  logic [W-1:0]  base_x,
  input  logic [W-1:0]  base_y,
  input  logic [W-1:0]  prime,
  output logic          done,
  output logic [W-1:0]  x_out,
  output logic [W-1:0]  y_out,
  output logic [W-1:0]  z_out,
  output logic          at_inf
);
  localparam int BIT_W = (KW > 1) ? $clog2(KW) : 1;

  typedef enum logic [2:0] {ST_IDLE, ST_INIT, ST_EXEC, ST_WAIT, ST_OUT} st_e;

  st_e              st;
  logic [PC_W-1:0]  pc;
  logic [BIT_W-1:0] bit_idx;
  logic [KW-1:0]    k_r;
  logic [W-1:0]     p_r, px_r, py_r;
  logic [2:0]       init_cnt;
  logic [1:0]       out_cnt;

  uop_t cur;
  ecj_uprog u_prog (.pc(pc), .uop(cur));

  // register file: synchronous write, asynchronous read
  logic [W-1:0]     rf [RF_DEPTH];
  logic             rf_we;
  logic [RF_AW-1:0] rf_waddr, rd_addr_a;
  logic [W-1:0]     rf_wdata, rd_a, rd_b;

  assign rd_addr_a = (st == ST_OUT) ? RF_AW'(out_cnt) : cur.a;
  assign rd_a = rf[rd_addr_a];
  assign rd_b = rf[cur.b];

  always_ff @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  logic [W-1:0] add_y, sub_y, mul_y;
  logic         mul_start, mul_done;

  ecj_modarith #(.W(W), .SUBTRACT(1'b0)) u_add (.a(rd_a), .b(rd_b), .p(p_r), .y(add_y));
  ecj_modarith #(.W(W), .SUBTRACT(1'b1)) u_sub (.a(rd_a), .b(rd_b), .p(p_r), .y(sub_y));

  assign mul_start = (st == ST_EXEC) && (cur.op == UOP_MUL);

  ecj_modmul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .start(mul_start), .a(rd_a), .b(rd_b), .p(p_r),
    .done(mul_done), .y(mul_y)
  );

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = cur.d;
    rf_wdata = add_y;
    unique case (st)
      ST_INIT: begin
        rf_we    = 1'b1;
        rf_waddr = RF_AW'(init_cnt);
        unique case (init_cnt)
          3'd0, 3'd3: rf_wdata = px_r;
          3'd1, 3'd4: rf_wdata = py_r;
          default:    rf_wdata = W'(1);
        endcase
      end
      ST_EXEC: begin
        if (cur.op == UOP_ADD) begin
          rf_we = 1'b1;
        end else if (cur.op == UOP_SUB) begin
          rf_we    = 1'b1;
          rf_wdata = sub_y;
        end
      end
      ST_WAIT: begin
        rf_we    = mul_done;
        rf_wdata = mul_y;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pc       <= '0;
      bit_idx  <= '0;
      k_r      <= '0;
      p_r      <= '0;
      px_r     <= '0;
      py_r     <= '0;
      init_cnt <= '0;
      out_cnt  <= '0;
      done     <= 1'b0;
      x_out    <= '0;
      y_out    <= '0;
      z_out    <= '0;
      at_inf   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            k_r      <= scalar;
            p_r      <= prime;
            px_r     <= base_x;
            py_r     <= base_y;
            init_cnt <= '0;
            st       <= ST_INIT;
          end
        end
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == 3'd4) begin
            pc      <= '0;
            bit_idx <= BIT_W'(KW - 1);
            st      <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          unique case (cur.op)
            UOP_MUL: st <= ST_WAIT;
            UOP_ADD, UOP_SUB: pc <= pc + 1'b1;
            default: begin
              if ((pc < ADD_ENTRY) && k_r[bit_idx]) begin
                pc <= ADD_ENTRY;
              end else if (bit_idx == '0) begin
                out_cnt <= '0;
                st      <= ST_OUT;
              end else begin
                bit_idx <= bit_idx - 1'b1;
                pc      <= '0;
              end
            end
          endcase
        end
        ST_WAIT: begin
          if (mul_done) begin
            pc <= pc + 1'b1;
            st <= ST_EXEC;
          end
        end
        ST_OUT: begin
          out_cnt <= out_cnt + 1'b1;
          unique case (out_cnt)
            2'd0: x_out <= rd_a;
            2'd1: y_out <= rd_a;
            default: begin
              z_out  <= rd_a;
              at_inf <= (rd_a == '0);
              done   <= 1'b1;
              st     <= ST_IDLE;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_WRITE_RANGE: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wdata < p_r)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |=> ($stable(x_out) && $stable(y_out) && $stable(z_out))); // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_EXEC) || (st == ST_WAIT)) |=> (st != ST_INIT)); // R5
  AST_MUL_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    mul_done |-> (st == ST_WAIT)); // R9
endmodule

// File: tb/ecj_scalar_mul_test.sv
module ecj_scalar_mul_test;
  localparam int W  = 16;
  localparam int KW = 12;
  localparam longint unsigned PBIG = 65519;
  localparam longint unsigned PSML = 251;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [KW-1:0] scalar = '0;
  logic [W-1:0]  base_x = '0, base_y = '0, prime = '0;
  logic          done, at_inf;
  logic [W-1:0]  x_out, y_out, z_out;

  int nchk = 0, nfail = 0;
  bit summary_done = 1'b0;

  always #5 clk = ~clk;

  ecj_scalar_mul #(.W(W), .KW(KW)) uut (
    .clk(clk), .rst(rst), .start(start), .scalar(scalar), .base_x(base_x),
    .base_y(base_y), .prime(prime), .done(done), .x_out(x_out), .y_out(y_out),
    .z_out(z_out), .at_inf(at_inf)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
    end
  endtask

  function automatic longint unsigned fpow(longint unsigned b, longint unsigned e,
                                           longint unsigned p);
    longint unsigned r = 1;
    b = b % p;
    while (e > 0) begin
      if (e[0]) r = r * b % p;
      b = b * b % p;
      e = e >> 1;
    end
    return r;
  endfunction

  function automatic longint unsigned fsub(longint unsigned a, longint unsigned b,
                                           longint unsigned p);
    return (a + p - b) % p;
  endfunction

  function automatic void find_pt(input longint unsigned p, input longint unsigned x0,
                                  output longint unsigned px, output longint unsigned py);
    px = 0; py = 0;
    for (longint unsigned i = 0; i < p; i++) begin
      longint unsigned x = (x0 + i) % p;
      longint unsigned rhs = (x * x % p * x + 7) % p;
      longint unsigned y = fpow(rhs, (p + 1) / 4, p);
      if (y != 0 && (y * y % p) == rhs) begin
        px = x; py = y;
        break;
      end
    end
  endfunction

  // affine double-and-add with implied leading one; degenerate steps are sticky infinity
  function automatic void model(input int unsigned k, input longint unsigned p,
                                input longint unsigned px, input longint unsigned py,
                                output longint unsigned ex, output longint unsigned ey,
                                output bit einf);
    longint unsigned tx = px, ty = py, lam, nx;
    einf = 1'b0;
    for (int i = KW - 1; i >= 0; i--) begin
      if (!einf) begin
        if (ty == 0) einf = 1'b1;
        else begin
          lam = 3 * (tx * tx % p) % p * fpow(2 * ty % p, p - 2, p) % p;
          nx  = fsub(lam * lam % p, 2 * tx % p, p);
          ty  = fsub(lam * fsub(tx, nx, p) % p, ty, p);
          tx  = nx;
        end
      end
      if (k[i] && !einf) begin
        if (tx == px) einf = 1'b1;
        else begin
          lam = fsub(py, ty, p) * fpow(fsub(px, tx, p), p - 2, p) % p;
          nx  = fsub(fsub(lam * lam % p, tx, p), px, p);
          ty  = fsub(lam * fsub(tx, nx, p) % p, ty, p);
          tx  = nx;
        end
      end
    end
    ex = tx; ey = ty;
  endfunction

  task automatic wait_done(output int unsigned lat);
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk(1'b0, "R4 done timeout", 0, 1);
  endtask

  task automatic run(input int unsigned k, input longint unsigned p,
                     input longint unsigned px, input longint unsigned py,
                     output int unsigned lat);
    @(negedge clk);
    start = 1'b1; scalar = k[KW-1:0]; prime = p[W-1:0];
    base_x = px[W-1:0]; base_y = py[W-1:0];
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
  endtask

  task automatic check_result(input int unsigned k, input longint unsigned p,
                              input longint unsigned px, input longint unsigned py,
                              input string tag);
    longint unsigned ex, ey, zi, z2, ax, ay;
    bit einf;
    model(k, p, px, py, ex, ey, einf);
    chk(x_out < p && y_out < p && z_out < p, "R3 range", z_out, p);
    if (einf) begin
      chk(at_inf == 1'b1, "R2 flag", at_inf, 1);
      chk(z_out == 0, "R2 zero Z", z_out, 0);
    end else begin
      chk(at_inf == 1'b0, "R2 flag", at_inf, 0);
      chk(z_out != 0, "R2 nonzero Z", z_out, 1);
      zi = fpow(z_out, p - 2, p);
      z2 = zi * zi % p;
      ax = x_out * z2 % p;
      ay = y_out * z2 % p * zi % p;
      chk(ax == ex, {tag, " x"}, ax, ex);
      chk(ay == ey, {tag, " y"}, ay, ey);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    longint unsigned bx, by, sx, sy, x2, y2, ex, ey;
    int unsigned lat, l0, l1, l5, lall, l0s, k;
    bit einf, found;
    logic [W-1:0] hx, hy, hz;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    // R6: reset state
    chk(done == 0 && at_inf == 0, "R6 flags", {done, at_inf}, 0);
    chk(x_out == 0 && y_out == 0 && z_out == 0, "R6 outputs", x_out | y_out | z_out, 0);
    rst = 1'b0;

    find_pt(PBIG, longint'($urandom) % PBIG, bx, by);
    find_pt(PSML, longint'($urandom) % PSML, sx, sy);

    // R7 / R8: directed scalars
    run(0, PBIG, bx, by, l0);
    check_result(0, PBIG, bx, by, "R7 zero scalar");
    // R4: one-cycle pulse, then outputs hold
    hx = x_out; hy = y_out; hz = z_out;
    @(negedge clk);
    chk(done == 1'b0, "R4 pulse", done, 0);
    repeat (4) @(negedge clk);
    chk(x_out == hx && y_out == hy && z_out == hz, "R4 hold", x_out, hx);

    run(1, PBIG, bx, by, l1);
    check_result(1, PBIG, bx, by, "R1 k=1");
    run(5, PBIG, bx, by, l5);
    check_result(5, PBIG, bx, by, "R1 k=5");
    run((1 << KW) - 1, PBIG, bx, by, lall);
    check_result((1 << KW) - 1, PBIG, bx, by, "R7 all ones");
    chk(lall - l0 == KW * (l1 - l0), "R8 all-ones latency", lall - l0, KW * (l1 - l0));
    chk(l5 - l0 == 2 * (l1 - l0), "R8 two-bit latency", l5 - l0, 2 * (l1 - l0));

    // R9: timing independent of operand values and prime
    run(0, PSML, sx, sy, l0s);
    check_result(0, PSML, sx, sy, "R7 zero scalar small prime");
    chk(l0s == l0, "R9 latency vs prime", l0s, l0);

    // R1: random scalars on the large prime
    for (int i = 0; i < 8; i++) begin
      k = $urandom & ((1 << KW) - 1);
      find_pt(PBIG, longint'($urandom) % PBIG, x2, y2);
      run(k, PBIG, x2, y2, lat);
      check_result(k, PBIG, x2, y2, "R1 random");
    end

    // R2: random scalars on the small prime
    for (int i = 0; i < 5; i++) begin
      k = $urandom & ((1 << KW) - 1);
      run(k, PSML, sx, sy, lat);
      check_result(k, PSML, sx, sy, "R2 small prime");
    end

    // R2: directed degenerate case found with the model
    found = 1'b0;
    for (int unsigned c = 0; c < (1 << KW) && !found; c++) begin
      model(c, PSML, sx, sy, ex, ey, einf);
      if (einf) begin
        found = 1'b1;
        k = c;
      end
    end
    if (found) begin
      run(k, PSML, sx, sy, lat);
      check_result(k, PSML, sx, sy, "R2 degenerate");
    end

    // R5: a second start mid-run is ignored
    k = $urandom & ((1 << KW) - 1);
    @(negedge clk);
    start = 1'b1; scalar = k[KW-1:0]; prime = PBIG[W-1:0];
    base_x = bx[W-1:0]; base_y = by[W-1:0];
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1; scalar = ~k[KW-1:0]; prime = PSML[W-1:0];
    base_x = sx[W-1:0]; base_y = sy[W-1:0];
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check_result(k, PBIG, bx, by, "R5 ignored restart");
    @(negedge clk);
    chk(done == 1'b0, "R5 no second run", done, 0);

    summary();
    $finish;
  end
endmodule